// File: doc/BRIEF.md
# Sequential Instruction Prefetch Buffer

This block works in the address-fetch stage next to an instruction cache. When the cache reports a miss, the block does not ask memory for the one 32-byte line that is missing. It asks for a 64-byte block that starts at that line. The first line that comes back is handed to the cache on the fill port. The second line, the one that follows in sequence, is held in a one-line side buffer together with its line address.

If a later cache miss names exactly the held line, memory is not used for it. The held line goes to the cache one cycle after the miss is accepted. The buffer is then emptied, and a new 64-byte request is issued starting at the line after the one just served. That request sends one more line to the cache and refills the buffer, so a stream of code that runs straight ahead keeps finding its next line nearby. A miss to any other address empties the buffer and starts a new block request.

The block handles one transaction at a time. Addresses at every port are line addresses, meaning the byte address shifted right by the line-offset width. Memory answers each request with two data beats, in order.

Top module: `seq_prefetch_buf`

## Requirements
- R1: After reset, `miss_ready` is 1, and `mem_req_valid` and `fill_valid` are 0. The buffer is empty, so the first miss to any address is fetched from memory.
- R2: A miss accepted while the buffer holds a different line (or nothing) raises `mem_req_valid` in the next cycle. `mem_req_addr` equals the miss line address, and memory is expected to return two 32-byte beats for it.
- R3: The first returned beat appears on the fill port for exactly one cycle, in the cycle after it arrives. It carries `fill_addr` equal to the requested line address and `fill_from_buf` = 0.
- R4: The second returned beat is not sent to the fill port. It is kept in the buffer under the tag requested address + 1, taken modulo 2^LA_W.
- R5: A miss whose line address equals the held tag, while the buffer is valid, is a buffer hit. In the cycle after acceptance, `fill_valid` = 1, `fill_from_buf` = 1, `fill_addr` is the miss address, and `fill_data` is the stored line. No memory request is made for that line.
- R6: After a buffer hit, the buffer is emptied. In the cycle after acceptance, `mem_req_valid` rises with address hit address + 1, and that request is then handled as in R2 to R4.
- R7: A miss that does not match the held tag discards the buffer. A later miss to the discarded tag is fetched from memory.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and `mem_req_addr` does not change.
- R9: `miss_ready` is 0 from the cycle after a miss is accepted until the second beat of its block (or of the prefetch that follows a hit) has been stored. It is 1 again in the cycle after that beat. A miss held on `miss_valid` while the block is busy is accepted at that point.
- R10: The line address wraps. A miss to the all-ones line address stores line 0 in the buffer, and a following miss to line 0 is a buffer hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | Cache reports a missing line |
| miss_addr | input | LA_W | Line address of the missing line |
| miss_ready | output | 1 | Block is idle and accepts a miss |
| mem_req_valid | output | 1 | 64-byte block request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | LA_W | First line address of the requested block |
| mem_rsp_valid | input | 1 | One 32-byte beat is returned |
| mem_rsp_data | input | LINE_W | Returned line data |
| fill_valid | output | 1 | A line is written into the cache |
| fill_addr | output | LA_W | Line address of the fill |
| fill_data | output | LINE_W | Line data of the fill |
| fill_from_buf | output | 1 | 1 when the fill came from the side buffer |

## Verification
The hardest situation to reach from the ports is a buffer hit that comes right after the buffer has been discarded or refilled. An example is a miss to a line that was held earlier but was thrown away when a non-matching miss arrived. Another is a hit on a line that only got into the buffer through the prefetch started by an earlier hit. The stimulus builds these cases on purpose with chains of misses: A, A+1, A+3; then B, C, B+1, B+2; and the all-ones line followed by line 0. Memory request stalls and gaps between beats vary, and one miss is held on the port while the block is still busy.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    typedef enum logic [1:0] {
        PF_IDLE  = 2'd0,
        PF_REQ   = 2'd1,
        PF_BEAT0 = 2'd2,
        PF_BEAT1 = 2'd3
    } pf_state_e;
endpackage

// File: rtl/pfb_line_store.sv
module pfb_line_store #(
    parameter int LA_W   = 27,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LA_W-1:0]   wr_tag,
    input  logic [LINE_W-1:0] wr_data,
    input  logic              clr,
    input  logic [LA_W-1:0]   lk_addr,
    output logic              hit,
    output logic [LINE_W-1:0] rd_data
);
    typedef struct packed {
        logic              vld;
        logic [LA_W-1:0]   tag;
        logic [LINE_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (clr) begin
            slot_d.vld = 1'b0;
        end
        if (wr_en) begin
            slot_d.vld  = 1'b1;
            slot_d.tag  = wr_tag;
            slot_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign hit     = slot_q.vld && (slot_q.tag == lk_addr);
    assign rd_data = slot_q.data;

    // R7: discard and store never collide
    a_r7_clr_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && clr));

    // R4: a stored line matches its own tag in the next cycle
    a_r4_tag_stored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((lk_addr == $past(wr_tag)) == hit));
endmodule

// File: rtl/pfb_fill_stage.sv
module pfb_fill_stage #(
    parameter int LA_W   = 27,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [LA_W-1:0]   ld_addr,
    input  logic [LINE_W-1:0] ld_data,
    input  logic              ld_buf,
    output logic              fill_valid,
    output logic [LA_W-1:0]   fill_addr,
    output logic [LINE_W-1:0] fill_data,
    output logic              fill_from_buf
);
    typedef struct packed {
        logic              vld;
        logic              src;
        logic [LA_W-1:0]   addr;
        logic [LINE_W-1:0] data;
    } fill_t;

    fill_t fl_d, fl_q;

    always_comb begin
        fl_d     = fl_q;
        fl_d.vld = ld;
        if (ld) begin
            fl_d.src  = ld_buf;
            fl_d.addr = ld_addr;
            fl_d.data = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign fill_valid    = fl_q.vld;
    assign fill_from_buf = fl_q.src;
    assign fill_addr     = fl_q.addr;
    assign fill_data     = fl_q.data;

    // R3: a fill pulse lasts a single cycle
    a_r3_fill_single: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid);
endmodule

// File: rtl/seq_prefetch_buf.sv
module seq_prefetch_buf
    import pfb_pkg::*;
#(
    parameter  int ADDR_W     = 32,
    parameter  int LINE_BYTES = 32,
    localparam int OFS_W      = $clog2(LINE_BYTES),
    localparam int LA_W       = ADDR_W - OFS_W,
    localparam int LINE_W     = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [LA_W-1:0]   miss_addr,
    output logic              miss_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [LA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data,
    output logic              fill_valid,
    output logic [LA_W-1:0]   fill_addr,
    output logic [LINE_W-1:0] fill_data,
    output logic              fill_from_buf
);
    localparam logic [LA_W-1:0] LINE_STEP = LA_W'(1);

    typedef struct packed {
        pf_state_e       st;
        logic [LA_W-1:0] addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              buf_hit;
    logic [LINE_W-1:0] buf_data;
    logic              st_wr, st_clr;
    logic [LA_W-1:0]   st_tag;
    logic              ld, ld_buf;
    logic [LA_W-1:0]   ld_addr;
    logic [LINE_W-1:0] ld_data;

    always_comb begin
        ctl_d   = ctl_q;
        st_wr   = 1'b0;
        st_clr  = 1'b0;
        st_tag  = ctl_q.addr + LINE_STEP;
        ld      = 1'b0;
        ld_buf  = 1'b0;
        ld_addr = ctl_q.addr;
        ld_data = mem_rsp_data;
        unique case (ctl_q.st)
            PF_IDLE: begin
                if (miss_valid) begin
                    st_clr   = 1'b1;
                    ctl_d.st = PF_REQ;
                    if (buf_hit) begin
                        ld         = 1'b1;
                        ld_buf     = 1'b1;
                        ld_addr    = miss_addr;
                        ld_data    = buf_data;
                        ctl_d.addr = miss_addr + LINE_STEP;
                    end else begin
                        ctl_d.addr = miss_addr;
                    end
                end
            end
            PF_REQ: begin
                if (mem_req_ready) begin
                    ctl_d.st = PF_BEAT0;
                end
            end
            PF_BEAT0: begin
                if (mem_rsp_valid) begin
                    ld       = 1'b1;
                    ctl_d.st = PF_BEAT1;
                end
            end
            PF_BEAT1: begin
                if (mem_rsp_valid) begin
                    st_wr    = 1'b1;
                    ctl_d.st = PF_IDLE;
                end
            end
            default: ctl_d.st = PF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: PF_IDLE, addr: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign miss_ready    = (ctl_q.st == PF_IDLE);
    assign mem_req_valid = (ctl_q.st == PF_REQ);
    assign mem_req_addr  = ctl_q.addr;

    pfb_line_store #(.LA_W(LA_W), .LINE_W(LINE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr),
        .wr_tag  (st_tag),
        .wr_data (mem_rsp_data),
        .clr     (st_clr),
        .lk_addr (miss_addr),
        .hit     (buf_hit),
        .rd_data (buf_data)
    );

    pfb_fill_stage #(.LA_W(LA_W), .LINE_W(LINE_W)) u_fill (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld            (ld),
        .ld_addr       (ld_addr),
        .ld_data       (ld_data),
        .ld_buf        (ld_buf),
        .fill_valid    (fill_valid),
        .fill_addr     (fill_addr),
        .fill_data     (fill_data),
        .fill_from_buf (fill_from_buf)
    );

    // R8: a stalled request holds still
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R5: a hit fills from the buffer one cycle later
    a_r5_hit_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && buf_hit) |=>
            (fill_valid && fill_from_buf && fill_addr == $past(miss_addr)));

    // R6: a hit starts the prefetch of the next line
    a_r6_prefetch_next: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_ready && buf_hit) |=>
            (mem_req_valid && mem_req_addr == $past(miss_addr) + LINE_STEP));

    // R9: no new miss while a request or fill is in progress
    a_r9_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !miss_ready);
    a_r9_busy_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !miss_ready);

    // R2: memory beats only arrive while a block is awaited
    a_r2_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> (ctl_q.st == PF_BEAT0 || ctl_q.st == PF_BEAT1));
endmodule

// File: tb/sim_seq_prefetch_buf.sv
`timescale 1ns/1ps
module sim_seq_prefetch_buf;
    localparam int LA_W   = 27;
    localparam int LINE_W = 256;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_valid = 1'b0;
    logic [LA_W-1:0]   miss_addr = '0;
    logic              miss_ready;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [LA_W-1:0]   mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [LINE_W-1:0] mem_rsp_data = '0;
    logic              fill_valid;
    logic [LA_W-1:0]   fill_addr;
    logic [LINE_W-1:0] fill_data;
    logic              fill_from_buf;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    seq_prefetch_buf u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_ready(miss_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .fill_from_buf(fill_from_buf)
    );

    function automatic logic [LINE_W-1:0] line_of(input logic [LA_W-1:0] a);
        logic [LINE_W-1:0] r;
        for (int k = 0; k < 8; k++) begin
            r[k*32 +: 32] = (32'(a) * 32'h9E3779B1) + (32'(k) * 32'h01000193) ^ 32'h5A5A0000;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [LINE_W-1:0] act,
                       input logic [LINE_W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model: phase 0 idle, 1 requesting, 2 first beat, 3 second beat
    int                m_phase = 0;
    logic [LA_W-1:0]   m_addr  = '0;
    bit                b_valid = 1'b0;
    logic [LA_W-1:0]   b_tag   = '0;
    logic [LINE_W-1:0] b_data  = '0;
    bit                e_fill  = 1'b0;
    bit                e_buf   = 1'b0;
    logic [LA_W-1:0]   e_addr  = '0;
    logic [LINE_W-1:0] e_data  = '0;
    bit                acc_seen = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_phase = 0; b_valid = 0; e_fill = 0;
        end else begin
            e_fill = 0;
            if (miss_valid && miss_ready) acc_seen = 1;
            if (m_phase == 0) begin
                if (miss_valid) begin
                    if (b_valid && b_tag == miss_addr) begin
                        e_fill = 1; e_buf = 1; e_addr = miss_addr; e_data = b_data;
                        m_addr = miss_addr + LA_W'(1);
                    end else begin
                        m_addr = miss_addr;
                    end
                    b_valid = 0;
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (mem_req_ready) m_phase = 2;
            end else if (m_phase == 2) begin
                if (mem_rsp_valid) begin
                    e_fill = 1; e_buf = 0; e_addr = m_addr; e_data = mem_rsp_data;
                    m_phase = 3;
                end
            end else begin
                if (mem_rsp_valid) begin
                    b_valid = 1; b_tag = m_addr + LA_W'(1); b_data = mem_rsp_data;
                    m_phase = 0;
                end
            end
        end
    end

    // compare every cycle, away from the active edge
    bit                got_fill = 0;
    bit                cap_buf  = 0;
    logic [LA_W-1:0]   cap_addr = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            chk(miss_ready == (m_phase == 0), "R9 miss_ready", LINE_W'(miss_ready), LINE_W'(m_phase == 0));
            chk(mem_req_valid == (m_phase == 1), "R2/R6 mem_req_valid", LINE_W'(mem_req_valid),
                LINE_W'(m_phase == 1));
            if (m_phase == 1)
                chk(mem_req_addr == m_addr, "R2/R6/R8 mem_req_addr", LINE_W'(mem_req_addr), LINE_W'(m_addr));
            chk(fill_valid == e_fill, "R3/R5 fill_valid", LINE_W'(fill_valid), LINE_W'(e_fill));
            if (e_fill && fill_valid) begin
                chk(fill_addr == e_addr, "R3/R5 fill_addr", LINE_W'(fill_addr), LINE_W'(e_addr));
                chk(fill_data == e_data, e_buf ? "R4/R5 fill_data" : "R3 fill_data", fill_data, e_data);
                chk(fill_from_buf == e_buf, "R3/R5 fill_from_buf", LINE_W'(fill_from_buf), LINE_W'(e_buf));
            end
            if (fill_valid && !got_fill) begin
                got_fill = 1; cap_buf = fill_from_buf; cap_addr = fill_addr;
            end
        end
    end

    // memory responder with varying stalls and gaps
    int unsigned seed = 32'h1234_5678;
    initial begin
        logic [LA_W-1:0] ra;
        int stall, gap, gap2;
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                seed  = seed * 32'd1103515245 + 32'd12345;
                stall = int'((seed >> 16) & 3);
                gap   = int'((seed >> 20) & 3);
                gap2  = int'((seed >> 24) & 1);
                repeat (stall) @(negedge clk);
                mem_req_ready = 1'b1; ra = mem_req_addr;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (gap) @(negedge clk);
                mem_rsp_valid = 1'b1; mem_rsp_data = line_of(ra);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                repeat (gap2) @(negedge clk);
                mem_rsp_valid = 1'b1; mem_rsp_data = line_of(ra + LA_W'(1));
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic wait_idle();
        do @(negedge clk); while (!miss_ready);
    endtask

    // exp_buf: 1 served by buffer, 0 served by memory, -1 not checked
    task automatic do_miss(input logic [LA_W-1:0] a, input int exp_buf, input string tag);
        got_fill = 0; acc_seen = 0;
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = a;
        do @(negedge clk); while (!acc_seen);
        miss_valid = 1'b0;
        wait_idle();
        if (exp_buf >= 0) begin
            chk(got_fill && cap_buf == exp_buf[0], tag, LINE_W'(cap_buf), LINE_W'(exp_buf));
            chk(cap_addr == a, tag, LINE_W'(cap_addr), LINE_W'(a));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(miss_ready == 1'b1, "R1 miss_ready", LINE_W'(miss_ready), LINE_W'(1));
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid", LINE_W'(mem_req_valid), LINE_W'(0));
        chk(fill_valid == 1'b0, "R1 fill_valid", LINE_W'(fill_valid), LINE_W'(0));

        do_miss(27'h0001000, 0, "R1/R2 first miss from memory");
        do_miss(27'h0001001, 1, "R4/R5 next line from buffer");
        do_miss(27'h0001003, 1, "R6 prefetched line from buffer");

        do_miss(27'h0002345, 0, "R7 miss B");
        do_miss(27'h0007777, 0, "R7 miss C discards B+1");
        do_miss(27'h0002346, 0, "R7 discarded tag refetched");
        do_miss(27'h0002347, 1, "R7 refilled buffer hits");

        // R9: second miss held on the port while busy
        got_fill = 0; acc_seen = 0;
        @(negedge clk);
        miss_valid = 1'b1; miss_addr = 27'h0000400;
        do @(negedge clk); while (!acc_seen);
        acc_seen = 0; miss_addr = 27'h0000401;
        do @(negedge clk); while (!acc_seen);
        miss_valid = 1'b0;
        wait_idle();
        chk(cap_buf == 1'b0, "R9 held miss first fill from memory", LINE_W'(cap_buf), LINE_W'(0));

        // R10: wrap of the line address
        do_miss('1, 0, "R10 top line from memory");
        do_miss('0, 1, "R10 wrapped line from buffer");

        for (int i = 0; i < 60; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            if (seed[27]) do_miss(miss_addr + LA_W'(seed[28] ? 1 : 2), -1, "R5/R7 sweep");
            else          do_miss(LA_W'(seed >> 8), -1, "R2/R7 sweep");
        end
        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule